// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Unit

This block connects a 32-bit load/store datapath to a byte-addressed memory port that is 32 bits wide. A request carries a byte address, a size code, a write flag, a signed flag and, for stores, register data. The block clears the two low address bits to form the word address. It raises the byte enables of the lanes the access touches and places the store data on those lanes. For loads it raises a read strobe.

Read data comes back on the cycle after the read strobe. The block then picks the addressed byte or halfword out of the returned word and zero-extends or sign-extends it to 32 bits, and flags the result valid for that one cycle. Byte ordering inside a word is little-endian or big-endian. The order is sampled from a configuration pin while reset is held and stays fixed until the next reset. Accesses that do not fit their natural alignment are flagged and never reach memory. They are not split.

Top module: `ls_lane_unit`

## Requirements
- R1: `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R2: The byte order is taken from `cfg_big_endian` (1 = big-endian) on every clock edge where `rst_n` is low. After reset is released, changes on that pin have no effect on lane placement.
- R3: Size code 00 is a byte access. It enables exactly one lane: lane k (bits 8k+7:8k) with k = addr[1:0] in little-endian mode, or k = 3 − addr[1:0] in big-endian mode.
- R4: Size code 01 is a halfword access. In little-endian mode it enables lanes 1:0 for addr[1]=0 and lanes 3:2 for addr[1]=1. In big-endian mode the two pairs swap.
- R5: Size code 10 is a word access. It enables all four lanes and passes the word through unchanged in either byte order.
- R6: On a store, a byte is copied onto all four lanes and a halfword onto both halves of `mem_wdata`. `mem_we` is high only for an aligned store.
- R7: An aligned load raises `mem_re`. One cycle later `ld_valid` is high and `ld_data` holds the addressed byte or halfword of `mem_rdata`. Bytes at increasing addresses form increasing significance in little-endian mode and decreasing significance in big-endian mode. The upper bits are zero-filled when `req_signed` is 0.
- R8: With `req_signed` = 1, a byte load copies its bit 7 and a halfword load copies its bit 15 into all higher result bits. On word loads the flag has no effect.
- R9: `misalign` is raised for size 11, for a halfword access with addr[0] = 1, or for a word access with addr[1:0] ≠ 0. In those cases `mem_be` is zero, `mem_we` and `mem_re` stay low, and no `ld_valid` follows.
- R10: A store issued in the same cycle as a load's data return does not disturb that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; byte order sampled while low |
| cfg_big_endian | input | 1 | Byte order select, 1 = big-endian |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, value in the low bits |
| mem_rdata | input | 32 | Word returned one cycle after `mem_re` |
| mem_addr | output | AW | Word-aligned address |
| mem_be | output | 4 | Lane enables |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 32 | Lane-placed store data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment error on the current request |

## Verification
A load's data return and a new request can occur in the same cycle. The new request may be a store to different lanes or an access flagged as misaligned. The bench drives a fresh random request in every cycle, so returns from load requests overlap with whatever follows, and it changes `mem_rdata` in each cycle. Reference functions rebuild the lane enables, the store word and the extended load value from byte addresses and the latched byte order. The current request's outputs and the previous load's result are compared against them in one sample taken between clock edges.

// File: rtl/ls_lane_unit.sv
module ls_lane_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_big_endian,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic          mem_we,
  output logic          mem_re,
  output logic [31:0]   mem_wdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  output logic          misalign
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;

  logic       big_q;
  logic [1:0] ofs, lane_b, lane_h, lane_sel;
  logic       bad, go;
  logic [3:0] be_raw;

  logic       pend_q, sgn_q;
  logic [1:0] lane_q, size_q;
  logic [7:0] ld_b;
  logic [15:0] ld_h;

  assign ofs    = req_addr[1:0];
  assign lane_b = big_q ? ~ofs : ofs;
  assign lane_h = {big_q ^ ofs[1], 1'b0};

  assign bad = (req_size == 2'b11) ||
               (req_size == SZ_H && ofs[0]) ||
               (req_size == SZ_W && ofs != 2'b00);
  assign go       = req_valid && !bad;
  assign misalign = req_valid && bad;

  always_comb begin
    case (req_size)
      SZ_B:    be_raw = 4'b0001 << lane_b;
      SZ_H:    be_raw = 4'b0011 << lane_h;
      default: be_raw = 4'b1111;
    endcase
  end

  always_comb begin
    case (req_size)
      SZ_B:    mem_wdata = {4{req_wdata[7:0]}};
      SZ_H:    mem_wdata = {2{req_wdata[15:0]}};
      default: mem_wdata = req_wdata;
    endcase
  end

  assign mem_addr = {req_addr[AW-1:2], 2'b00};
  assign mem_be   = go ? be_raw : 4'b0000;
  assign mem_we   = go && req_write;
  assign mem_re   = go && !req_write;
  assign lane_sel = (req_size == SZ_H) ? lane_h : lane_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      big_q  <= cfg_big_endian;
      pend_q <= 1'b0;
      lane_q <= 2'b00;
      size_q <= SZ_W;
      sgn_q  <= 1'b0;
    end else begin
      pend_q <= mem_re;
      if (mem_re) begin
        lane_q <= lane_sel;
        size_q <= req_size;
        sgn_q  <= req_signed;
      end
    end
  end

  always_comb begin
    case (lane_q)
      2'd0:    ld_b = mem_rdata[7:0];
      2'd1:    ld_b = mem_rdata[15:8];
      2'd2:    ld_b = mem_rdata[23:16];
      default: ld_b = mem_rdata[31:24];
    endcase
  end

  assign ld_h = lane_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (size_q)
      SZ_B:    ld_data = {{24{sgn_q & ld_b[7]}}, ld_b};
      SZ_H:    ld_data = {{16{sgn_q & ld_h[15]}}, ld_h};
      default: ld_data = mem_rdata;
    endcase
  end

  assign ld_valid = pend_q;
endmodule

// File: rtl/ls_lane_unit_chk.sv
module ls_lane_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_size,
  input logic       misalign,
  input logic       mem_we,
  input logic       mem_re,
  input logic [3:0] mem_be,
  input logic       ld_valid,
  input logic       mode
);
  a_r9_no_strobe_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_we && !mem_re && mem_be == 4'b0000));

  a_r9_error_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> req_valid);

  a_r3_r4_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |->
      ($countones(mem_be) == ((req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4)));

  a_r7_return_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ld_valid == $past(mem_re)));

  a_r2_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));
endmodule

bind ls_lane_unit ls_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .misalign(misalign), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
  .ld_valid(ld_valid), .mode(big_q)
);

// File: tb/sim_ls_lane_unit.sv
module sim_ls_lane_unit;
  logic clk = 1'b0;
  logic rst_n, cfg_big_endian, req_valid, req_write, req_signed;
  logic [1:0] req_size;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0] mem_be;
  logic mem_we, mem_re, ld_valid, misalign;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit mode_big;
  bit p_valid, p_sgn;
  logic [1:0] p_size, p_ofs;

  always #2 clk = ~clk;

  ls_lane_unit u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int f_lane(bit big, int byte_ofs);
    return big ? 3 - byte_ofs : byte_ofs;
  endfunction

  function automatic int f_len(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit f_bad(logic [1:0] sz, logic [1:0] o);
    return sz == 2'b11 || (sz == 2'b01 && o[0]) || (sz == 2'b10 && o != 0);
  endfunction

  function automatic logic [3:0] f_be(bit big, logic [1:0] sz, logic [1:0] o);
    logic [3:0] b = 0;
    int base = (sz == 2'b10) ? 0 : int'(o);
    for (int i = 0; i < f_len(sz); i++) b[f_lane(big, base + i)] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] f_wd(logic [1:0] sz, logic [31:0] d);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      if (sz == 2'b00) r[8*k +: 8] = d[7:0];
      else if (sz == 2'b01) r[8*k +: 8] = d[8*(k%2) +: 8];
      else r[8*k +: 8] = d[8*k +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] f_ld(bit big, logic [1:0] sz, logic [1:0] o, bit sg,
                                       logic [31:0] w);
    logic [31:0] v = 0;
    int n = f_len(sz);
    int base = (n == 4) ? 0 : int'(o);
    logic [7:0] bt;
    for (int i = 0; i < n; i++) begin
      bt = w[8*f_lane(big, base + i) +: 8];
      if (big) v = (v << 8) | {24'h0, bt};
      else v = v | ({24'h0, bt} << (8*i));
    end
    if (sg && n == 1 && v[7]) v[31:8] = '1;
    if (sg && n == 2 && v[15]) v[31:16] = '1;
    return v;
  endfunction

  task automatic step(bit v, bit w, logic [1:0] sz, bit sg, logic [31:0] a,
                      logic [31:0] wd, logic [31:0] rd);
    string t;
    bit err, go;
    @(negedge clk);
    req_valid = v; req_write = w; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd; mem_rdata = rd;
    #1;
    err = v && f_bad(sz, a[1:0]);
    go = v && !err;
    t = (sz == 2'b00) ? "R3" : (sz == 2'b01) ? "R4" : "R5";
    chk("R1", mem_addr, {a[31:2], 2'b00});
    chk("R9", {31'h0, misalign}, {31'h0, err});
    chk(err ? "R9" : t, {28'h0, mem_be}, go ? {28'h0, f_be(mode_big, sz, a[1:0])} : 32'h0);
    chk("R6", {31'h0, mem_we}, {31'h0, go && w});
    chk("R7", {31'h0, mem_re}, {31'h0, go && !w});
    if (go && w) chk("R6", mem_wdata, f_wd(sz, wd));
    chk("R10", {31'h0, ld_valid}, {31'h0, p_valid});
    if (p_valid)
      chk(p_sgn ? "R8" : "R7", ld_data, f_ld(mode_big, p_size, p_ofs, p_sgn, rd));
    p_valid = go && !w; p_size = sz; p_ofs = a[1:0]; p_sgn = sg;
  endtask

  task automatic do_reset(bit big);
    @(negedge clk);
    rst_n = 1'b0; cfg_big_endian = big; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mode_big = big; p_valid = 0;
    #1;
    chk("R7", {31'h0, ld_valid}, 32'h0);
    chk("R9", {28'h0, mem_be, mem_we, mem_re, misalign}, 32'h0);
  endtask

  task automatic rand_run(int n);
    logic [31:0] a;
    logic [1:0] sz;
    for (int i = 0; i < n; i++) begin
      sz = 2'($urandom_range(0, 3));
      a = $urandom;
      if ($urandom_range(0, 3) != 0) begin
        if (sz == 2'b01) a[0] = 1'b0;
        if (sz == 2'b10) a[1:0] = 2'b00;
      end
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, sz,
           $urandom_range(0, 1) == 1, a, $urandom, $urandom);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    req_write = 0; req_size = 0; req_signed = 0; req_addr = 0;
    req_wdata = 0; mem_rdata = 0; req_valid = 0; rst_n = 0; cfg_big_endian = 0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m == 1);
      // R2: flipping the pin after reset must not change lane placement
      cfg_big_endian = (m == 0);
      step(1, 1, 2'b00, 0, 32'h0000_1000, 32'h0000_00A5, 0);
      chk("R2", {28'h0, mem_be}, m == 1 ? 32'h8 : 32'h1);
      // R8: signed halfword and byte, then unsigned byte
      step(1, 0, 2'b01, 1, 32'h0000_0002, 0, 0);
      step(1, 0, 2'b00, 1, 32'h0000_0003, 0, 32'h8000_8000);
      step(1, 0, 2'b00, 0, 32'h0000_0001, 0, 32'h8080_8080);
      // R5: word load ignores signed flag; R9: misaligned word and halfword
      step(1, 0, 2'b10, 1, 32'h0000_0010, 0, 32'h0000_0080);
      step(1, 1, 2'b10, 0, 32'h0000_0013, 32'hDEAD_BEEF, 32'hF00D_CAFE);
      step(1, 0, 2'b01, 0, 32'h0000_0021, 0, 0);
      step(1, 0, 2'b11, 0, 32'h0000_0020, 0, 0);
      // R10: load followed by a store in its return cycle
      step(1, 0, 2'b01, 0, 32'h0000_0040, 0, 0);
      step(1, 1, 2'b00, 0, 32'h0000_0045, 32'h0000_0077, 32'h1234_5678);
      step(0, 0, 2'b00, 0, 0, 0, 0);
      rand_run(3000);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule